// File: doc/BRIEF.md
# Card Host Access Cycle Decoder

This block sits on the card side of a removable storage card's host bus. It turns the host's asynchronous active-low strobes into clean, clock-aligned register-select and enable outputs. It serves three operating modes: a memory mode, an I/O mode and a disk-style task-file mode. The disk-style mode is fixed by a strap. If the output-enable strobe is held low at the first clock after reset is released, the block latches disk-style mode until the next reset. Otherwise a configuration input from the downstream option register chooses between memory mode and I/O mode.

Every strobe passes through a two-flop synchroniser, and so does the space-select line. The block then classifies each cycle as one of three accesses: common memory, attribute/configuration register, or I/O register. When the I/O write strobe deasserts, the block captures the raw address and data buses. It issues one single-cycle write pulse and sets a sticky valid flag. Read enables are levels that follow the synchronised strobes. The reset input is expected to come from a reset that asserts asynchronously and is released synchronously to `clk`.

Top module: `card_cycle_decoder`

## Requirements
- R1: When `out_en_b` is low at the first rising clock edge after `rst_n` rises, `mode_o` becomes 2'b10 (disk-style) at that edge. It stays 2'b10 whatever `out_en_b` or `io_cfg_en` do afterwards, until the next reset.
- R2: When `out_en_b` is high at that edge, `mode_o` is 2'b01 (I/O) while `io_cfg_en` is 1 and 2'b00 (memory) while it is 0. A change of `io_cfg_en` shows on the next clock edge.
- R3: In memory mode, `out_en_b` low with `space_sel` high drives `rd_common_o` high and `rd_attr_o` low.
- R4: In memory mode, `out_en_b` low with `space_sel` low drives `rd_attr_o` high and `rd_common_o` low. The two are never high together.
- R5: In I/O mode, `out_en_b` low drives `rd_attr_o` high whatever the level of `space_sel`. `rd_common_o` stays low.
- R6: In I/O mode, a rising edge of `io_wr_b` taken with `space_sel` low gives exactly one cycle of `wr_pulse_o`. In that same cycle `wr_addr_o` and `wr_data_o` take the buses and `wr_valid_o` is set. With `space_sel` high, no pulse is given and the held address is unchanged.
- R7: In memory mode, `io_wr_b` and `io_rd_b` have no effect: there is no pulse, no `rd_io_o`, and `wr_addr_o`/`wr_valid_o` keep their values.
- R8: In disk-style mode, `space_sel` is ignored. I/O writes pulse and I/O reads assert `rd_io_o` at either level, and `out_en_b` never raises `rd_common_o` or `rd_attr_o`.
- R9: In I/O mode, `io_rd_b` low with `space_sel` low drives `rd_io_o` high. With `space_sel` high it stays low.
- R10: Each output reacts at the third rising clock edge after its input pin changes, because of two synchroniser stages and one output register.
- R11: While `rst_n` is low, all enables, `wr_pulse_o`, `wr_valid_o`, `wr_addr_o` and `wr_data_o` are zero and `mode_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset, synchronously released |
| io_cfg_en | input | 1 | Option register selects the I/O interface |
| out_en_b | input | 1 | Host output-enable strobe, active low; mode strap |
| io_rd_b | input | 1 | Host I/O read strobe, active low |
| io_wr_b | input | 1 | Host I/O write strobe, active low |
| space_sel | input | 1 | Register-space select from host |
| host_addr | input | ADDR_W | Host address bus |
| host_data | input | DATA_W | Host write data bus |
| mode_o | output | 2 | 00 memory, 01 I/O, 10 disk-style |
| rd_common_o | output | 1 | Common memory read enable |
| rd_attr_o | output | 1 | Attribute/config register read enable |
| rd_io_o | output | 1 | I/O register read enable |
| wr_pulse_o | output | 1 | Single-cycle I/O register write enable |
| wr_valid_o | output | 1 | Captured write address/data are valid |
| wr_addr_o | output | ADDR_W | Address captured at last accepted write |
| wr_data_o | output | DATA_W | Data captured at last accepted write |

## Verification
In I/O mode the trailing edge of a write and the start of an attribute read can land in the same cycle. The bench forces this by raising `io_wr_b` and lowering `out_en_b` on the same drive edge. It then expects `wr_pulse_o` and `rd_attr_o` high together at the third edge, with the captured address correct. A separate case holds an I/O read and an attribute read at once and expects both enables high.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  typedef enum logic [1:0] {
    MODE_MEM  = 2'b00,
    MODE_IO   = 2'b01,
    MODE_DISK = 2'b10
  } acc_mode_e;

  // bit positions in the synchronised strobe vector
  localparam int SI_OE    = 0;
  localparam int SI_IORD  = 1;
  localparam int SI_IOWR  = 2;
  localparam int SI_SPACE = 3;
  localparam int SYNC_W   = 4;

endpackage

// File: rtl/ccd_sync.sv
module ccd_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ccd_mode_latch.sv
module ccd_mode_latch
  import ccd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strap_b,
  input  logic      io_cfg_en,
  output acc_mode_e mode_q
);

  logic      done_q, done_d;
  logic      disk_q, disk_d;
  acc_mode_e mode_d;

  // strap is static while sampled, so the raw pin is taken once
  always_comb begin
    done_d = 1'b1;
    disk_d = done_q ? disk_q : ~strap_b;
    if (disk_d)         mode_d = MODE_DISK;
    else if (io_cfg_en) mode_d = MODE_IO;
    else                mode_d = MODE_MEM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      disk_q <= 1'b0;
      mode_q <= MODE_MEM;
    end else begin
      done_q <= done_d;
      disk_q <= disk_d;
      mode_q <= mode_d;
    end
  end

  assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_q) && done_q) |-> $stable(disk_q));

  assert_disk_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_DISK) |-> (mode_q == MODE_DISK));

endmodule

// File: rtl/ccd_cycle_class.sv
module ccd_cycle_class
  import ccd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_mode_e         mode_q,
  input  logic [SYNC_W-1:0] strb_s,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  output logic              rd_common_q,
  output logic              rd_attr_q,
  output logic              rd_io_q,
  output logic              wr_pulse_q,
  output logic              wr_valid_q,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [DATA_W-1:0] wr_data_q
);

  logic              wr_prev_q;
  logic              is_mem, is_io, is_disk;
  logic              oe_act, iord_act, wr_rise, io_space_ok;
  logic              rd_common_d, rd_attr_d, rd_io_d, wr_pulse_d, wr_valid_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [DATA_W-1:0] wr_data_d;

  always_comb begin
    is_mem      = (mode_q == MODE_MEM);
    is_io       = (mode_q == MODE_IO);
    is_disk     = (mode_q == MODE_DISK);
    oe_act      = ~strb_s[SI_OE];
    iord_act    = ~strb_s[SI_IORD];
    wr_rise     = strb_s[SI_IOWR] & ~wr_prev_q;
    io_space_ok = (is_io & ~strb_s[SI_SPACE]) | is_disk;

    rd_common_d = is_mem & oe_act & strb_s[SI_SPACE];
    rd_attr_d   = (is_mem & oe_act & ~strb_s[SI_SPACE]) | (is_io & oe_act);
    rd_io_d     = iord_act & io_space_ok;
    wr_pulse_d  = wr_rise & io_space_ok;

    wr_valid_d  = wr_valid_q | wr_pulse_d;
    wr_addr_d   = wr_pulse_d ? host_addr : wr_addr_q;
    wr_data_d   = wr_pulse_d ? host_data : wr_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q   <= 1'b1;
      rd_common_q <= 1'b0;
      rd_attr_q   <= 1'b0;
      rd_io_q     <= 1'b0;
      wr_pulse_q  <= 1'b0;
      wr_valid_q  <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_prev_q   <= strb_s[SI_IOWR];
      rd_common_q <= rd_common_d;
      rd_attr_q   <= rd_attr_d;
      rd_io_q     <= rd_io_d;
      wr_pulse_q  <= wr_pulse_d;
      wr_valid_q  <= wr_valid_d;
      wr_addr_q   <= wr_addr_d;
      wr_data_q   <= wr_data_d;
    end
  end

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_q |=> !wr_pulse_q);

  assert_addr_only_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr_q != $past(wr_addr_q)) |-> wr_pulse_q);

  assert_space_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_common_q, rd_attr_q}));

  assert_mem_ignores_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_MEM) |-> (!wr_pulse_q && !rd_io_q));

  assert_disk_ignores_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_DISK) |-> (!rd_common_q && !rd_attr_q));

  assert_io_no_common_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_IO) |-> !rd_common_q);

endmodule

// File: rtl/card_cycle_decoder.sv
module card_cycle_decoder
  import ccd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_cfg_en,
  input  logic              out_en_b,
  input  logic              io_rd_b,
  input  logic              io_wr_b,
  input  logic              space_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  output logic [1:0]        mode_o,
  output logic              rd_common_o,
  output logic              rd_attr_o,
  output logic              rd_io_o,
  output logic              wr_pulse_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  logic [SYNC_W-1:0] strb_raw, strb_s;
  acc_mode_e         mode_q;

  always_comb begin
    strb_raw           = '1;
    strb_raw[SI_OE]    = out_en_b;
    strb_raw[SI_IORD]  = io_rd_b;
    strb_raw[SI_IOWR]  = io_wr_b;
    strb_raw[SI_SPACE] = space_sel;
  end

  ccd_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({SYNC_W{1'b1}})
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(strb_raw),
    .sync_o (strb_s)
  );

  ccd_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_b  (out_en_b),
    .io_cfg_en(io_cfg_en),
    .mode_q   (mode_q)
  );

  ccd_cycle_class #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_class (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .strb_s     (strb_s),
    .host_addr  (host_addr),
    .host_data  (host_data),
    .rd_common_q(rd_common_o),
    .rd_attr_q  (rd_attr_o),
    .rd_io_q    (rd_io_o),
    .wr_pulse_q (wr_pulse_o),
    .wr_valid_q (wr_valid_o),
    .wr_addr_q  (wr_addr_o),
    .wr_data_q  (wr_data_o)
  );

  assign mode_o = mode_q;

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid_o) |-> wr_valid_o);

endmodule

// File: tb/card_cycle_decoder_bench.sv
module card_cycle_decoder_bench;

  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          io_cfg_en, out_en_b, io_rd_b, io_wr_b, space_sel;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_data;
  logic [1:0]    mode_o;
  logic          rd_common_o, rd_attr_o, rd_io_o, wr_pulse_o, wr_valid_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;

  int nvec = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  card_cycle_decoder u_card_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .io_cfg_en(io_cfg_en), .out_en_b(out_en_b),
    .io_rd_b(io_rd_b), .io_wr_b(io_wr_b), .space_sel(space_sel),
    .host_addr(host_addr), .host_data(host_data), .mode_o(mode_o),
    .rd_common_o(rd_common_o), .rd_attr_o(rd_attr_o), .rd_io_o(rd_io_o),
    .wr_pulse_o(wr_pulse_o), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  // entry: [7]cfg [6]oe_b [5]iord_b [4]space [3]exp_common [2]exp_attr [1]exp_io
  localparam logic [7:0] VEC [9] = '{
    8'b0_0_1_1_1_0_0_0,  // R3 memory common read
    8'b0_0_1_0_0_1_0_0,  // R4 memory attribute read
    8'b0_1_0_0_0_0_0_0,  // R7 memory mode ignores I/O read
    8'b0_1_1_1_0_0_0_0,  // idle
    8'b1_0_1_1_0_1_0_0,  // R5 I/O mode attribute read, space high
    8'b1_0_1_0_0_1_0_0,  // R5 I/O mode attribute read, space low
    8'b1_1_0_0_0_0_1_0,  // R9 I/O read valid
    8'b1_1_0_1_0_0_0_0,  // R9 I/O read with space high rejected
    8'b1_0_0_0_0_1_1_0   // R5 R9 attribute and I/O read together
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    out_en_b = 1'b1; io_rd_b = 1'b1; io_wr_b = 1'b1; space_sel = 1'b1;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    idle_bus();
    out_en_b = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // drives a full I/O write; returns pulse count and the negedge index of the pulse
  task automatic io_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sp,
                          output int pulses, output int at);
    @(negedge clk);
    space_sel = sp; host_addr = a; host_data = d; io_wr_b = 1'b0;
    repeat (4) @(negedge clk);
    io_wr_b = 1'b1;
    pulses = 0; at = 0;
    for (int i = 1; i <= 6; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wr_pulse_o) begin pulses++; at = i; end
    end
    idle_bus();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int p, at;
    rst_n = 1'b0; io_cfg_en = 1'b0; host_addr = '0; host_data = '0;
    idle_bus();
    repeat (2) @(negedge clk);
    // R11 reset state
    chk({rd_common_o, rd_attr_o, rd_io_o, wr_pulse_o, wr_valid_o} == 5'b0, "R11 enables in reset",
        {rd_common_o, rd_attr_o, rd_io_o, wr_pulse_o, wr_valid_o}, 0);
    chk(wr_addr_o == '0 && wr_data_o == '0, "R11 captured regs in reset", wr_addr_o, 0);
    chk(mode_o == 2'b00, "R11 mode in reset", mode_o, 0);

    do_reset(1'b1);
    chk(mode_o == 2'b00, "R2 memory mode after strap high", mode_o, 0);

    // table walk
    for (int v = 0; v < 9; v++) begin
      @(negedge clk);
      idle_bus();
      io_cfg_en = VEC[v][7];
      repeat (5) @(negedge clk);
      chk(mode_o == {1'b0, VEC[v][7]}, "R2 mode follows cfg", mode_o, {1'b0, VEC[v][7]});
      out_en_b = VEC[v][6]; io_rd_b = VEC[v][5]; space_sel = VEC[v][4];
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk({rd_common_o, rd_attr_o, rd_io_o} == 3'b000, "R10 no response before third edge",
          {rd_common_o, rd_attr_o, rd_io_o}, 0);
      @(posedge clk);
      @(negedge clk);
      chk({rd_common_o, rd_attr_o, rd_io_o} == VEC[v][3:1],
          $sformatf("table vec %0d (R3 R4 R5 R7 R9 R10)", v),
          {rd_common_o, rd_attr_o, rd_io_o}, VEC[v][3:1]);
      chk(!wr_pulse_o, "R7 no write pulse during reads", wr_pulse_o, 0);
      idle_bus();
      repeat (4) @(negedge clk);
    end

    // R6 I/O mode writes
    io_cfg_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_valid_o, "R6 valid clear before first write", wr_valid_o, 0);
    io_write(11'h2A5, 8'h3C, 1'b0, p, at);
    chk(p == 1, "R6 one pulse per write", p, 1);
    chk(at == 3, "R10 pulse on third edge", at, 3);
    chk(wr_addr_o == 11'h2A5 && wr_data_o == 8'h3C, "R6 captured address/data",
        {wr_addr_o, wr_data_o}, {11'h2A5, 8'h3C});
    chk(wr_valid_o, "R6 valid set", wr_valid_o, 1);
    io_write(11'h111, 8'hEE, 1'b1, p, at);
    chk(p == 0, "R6 space high write rejected", p, 0);
    chk(wr_addr_o == 11'h2A5, "R6 address kept after rejected write", wr_addr_o, 11'h2A5);

    // R7 memory mode ignores writes
    io_cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    io_write(11'h7FF, 8'h81, 1'b0, p, at);
    chk(p == 0, "R7 memory mode write ignored", p, 0);
    chk(wr_addr_o == 11'h2A5 && wr_data_o == 8'h3C, "R7 captured regs unchanged",
        {wr_addr_o, wr_data_o}, {11'h2A5, 8'h3C});

    // simultaneous write trailing edge and attribute read in I/O mode
    io_cfg_en = 1'b1;
    repeat (3) @(negedge clk);
    space_sel = 1'b0; host_addr = 11'h055; host_data = 8'hA7; io_wr_b = 1'b0;
    repeat (4) @(negedge clk);
    io_wr_b = 1'b1; out_en_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_pulse_o && rd_attr_o, "R5 R6 write pulse and attribute read together",
        {wr_pulse_o, rd_attr_o}, 2'b11);
    chk(wr_addr_o == 11'h055, "R6 address in coincident cycle", wr_addr_o, 11'h055);
    @(posedge clk);
    @(negedge clk);
    chk(!wr_pulse_o && rd_attr_o, "R6 pulse ends, read level stays", {wr_pulse_o, rd_attr_o}, 2'b01);
    idle_bus();
    repeat (4) @(negedge clk);

    // R1 disk-style strap
    io_cfg_en = 1'b0;
    do_reset(1'b0);
    chk(mode_o == 2'b10, "R1 disk mode latched at first edge", mode_o, 2);
    chk(!wr_valid_o, "R11 valid cleared by reset", wr_valid_o, 0);
    out_en_b = 1'b1;
    io_cfg_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(mode_o == 2'b10, "R1 disk mode held after strap release", mode_o, 2);
    out_en_b = 1'b0; space_sel = 1'b0;
    repeat (4) @(negedge clk);
    chk(!rd_attr_o && !rd_common_o, "R8 output-enable ignored in disk mode",
        {rd_common_o, rd_attr_o}, 0);
    space_sel = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rd_attr_o && !rd_common_o, "R8 output-enable ignored, space high",
        {rd_common_o, rd_attr_o}, 0);
    idle_bus();
    io_write(11'h3F0, 8'h5A, 1'b1, p, at);
    chk(p == 1 && at == 3, "R8 disk write with space high", p, 1);
    chk(wr_addr_o == 11'h3F0 && wr_data_o == 8'h5A, "R8 disk write capture",
        {wr_addr_o, wr_data_o}, {11'h3F0, 8'h5A});
    io_write(11'h00F, 8'h11, 1'b0, p, at);
    chk(p == 1, "R8 disk write with space low", p, 1);
    @(negedge clk);
    space_sel = 1'b1; io_rd_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_io_o, "R8 disk I/O read with space high", rd_io_o, 1);
    idle_bus();
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule